// File: doc/BRIEF.md
# Segment Translation and Miss Reporter

This block is the front end of a 32-bit hashed-page address translator. For every access it decides where the physical address comes from. Real mode passes the address through when relocation for that access kind is off. Otherwise a block-mapping hit that permits the access wins. Failing both, segment translation runs. The upper four address bits pick one of sixteen segment registers. From that register the block derives a protection key, a virtual segment identifier, a primary hash and a compare tag. It then presents a lookup to an external translation cache, which answers in the same cycle.

When the access cannot complete, the block turns the outcome into the values a software miss handler or storage-fault handler needs. These are the missing address and its compare word (kept separately for fetches and for data), the addresses of the primary and secondary page-table groups, an error code, and the data fault address and status. The result of a request appears as a one-cycle pulse. The fault side values stay in registers until a later fault of the same class replaces them.

Top module: `seg_xlate_front`

## Requirements
- R1: Every request gives `rsp_valid` exactly one cycle later, for one cycle only, with exactly one of `rsp_grant` and `rsp_fault` set. Access kind encoding on `req_kind`: 0 load, 1 store, 2 fetch.
- R2: A fetch with `ir_en` low, or a load/store with `dr_en` low, is granted with `rsp_pa` equal to the effective address and raises no cache lookup. The enable of the other kind has no effect.
- R3: A block-mapping hit with `bat_ok` high is granted with `rsp_pa = bat_pa`. A hit with `bat_ok` low is ignored, and segment translation proceeds.
- R4: The segment register is selected by EA[31:28]. Its fields are: bit 31 direct-store (T), bit 30 supervisor key, bit 29 user key, bit 28 no-execute (N), bits 23:0 the segment identifier. The key is 1 when (user mode and bit 29) or (supervisor mode and bit 30).
- R5: With page index P = EA[27:12], the hash is VSID xor P. The compare tag is (VSID << 7) | (P >> 10). During a lookup, `tlb_ptem` carries the tag and `tlb_ea` carries the address, in the request cycle.
- R6: A fetch from a segment with N or T set faults with error code 0x10000000, without a lookup.
- R7: A load or store to a segment with T set is granted with `rsp_pa` equal to the effective address, without a lookup.
- R8: On a lookup with `tlb_hit` and `tlb_ok` high, the access is granted with `rsp_pa = tlb_pa`.
- R9: On a miss, the address is latched into `imiss` (fetch) or `dmiss` (data). The matching compare output `icmp` or `dcmp` becomes 0x80000000 | tag.
- R10: On a miss, `hash1` = base + ((hash & {mask,0x3FF}) << 6) and `hash2` is the same with the hash inverted.
- R11: The miss error code is bit 18 for a fetch, bit 16 for a store and no bit for a load, with the key at bit 19.
- R12: A hit without permission on a load or store sets `dar` to the address, error code 0, and `dsisr` to 0x0A000000 for a store or 0x08000000 for a load. On a fetch it sets error code 0x08000000.
- R13: Fault side registers change only on the cycle of a fault that owns them. Grants and faults of other classes leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| user_mode | input | 1 | 1 = user privilege |
| ir_en | input | 1 | Fetch relocation enable |
| dr_en | input | 1 | Data relocation enable |
| seg_regs | input | 512 | Sixteen 32-bit segment registers, register i at bits 32i+31:32i |
| htab_base | input | 32 | Page-table base address |
| htab_mask | input | 9 | Page-table size mask |
| bat_hit | input | 1 | Block-mapping match for this request |
| bat_ok | input | 1 | Block-mapping permits this access |
| bat_pa | input | 32 | Block-mapping physical address |
| tlb_lookup | output | 1 | Cache lookup strobe |
| tlb_ea | output | 32 | Lookup address |
| tlb_ptem | output | 31 | Lookup compare tag |
| tlb_hit | input | 1 | Cache match |
| tlb_ok | input | 1 | Cache entry permits the access |
| tlb_pa | input | 32 | Cache physical address |
| rsp_valid | output | 1 | Result pulse |
| rsp_grant | output | 1 | Access granted |
| rsp_fault | output | 1 | Access faulted |
| rsp_pa | output | 32 | Physical address of the last grant |
| err_code | output | 32 | Error code of the last fault |
| dsisr | output | 32 | Data fault status |
| dar | output | 32 | Data fault address |
| imiss | output | 32 | Fetch miss address |
| icmp | output | 32 | Fetch miss compare word |
| dmiss | output | 32 | Data miss address |
| dcmp | output | 32 | Data miss compare word |
| hash1 | output | 32 | Primary page-table group address |
| hash2 | output | 32 | Secondary page-table group address |

## Verification
The lookup outputs `tlb_lookup`, `tlb_ea` and `tlb_ptem` are combinational. They are due in the request cycle itself, so the bench checks them one time step after driving the request, before the clock edge. Every other result is registered once. The bench drives at a falling edge and checks all result and side registers at the next falling edge, half a cycle after the capturing edge. Periodic idle cycles confirm that the result pulse lasts one cycle. A shadow copy of every side register confirms that unrelated outcomes leave it unchanged.

// File: rtl/sxm_pkg.sv
package sxm_pkg;
  typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2} acc_kind_e;
  typedef enum logic [1:0] {OUT_GRANT, OUT_NOEXEC, OUT_PROT, OUT_MISS} outcome_e;
  typedef enum logic [1:0] {PA_EA, PA_BAT, PA_TLB} pa_src_e;

  localparam int SR_W      = 32;
  localparam int SR_T_BIT  = 31;
  localparam int SR_KS_BIT = 30;
  localparam int SR_KP_BIT = 29;
  localparam int SR_N_BIT  = 28;

  localparam logic [31:0] ERR_NOEXEC   = 32'h1000_0000;
  localparam logic [31:0] ERR_PROT_I   = 32'h0800_0000;
  localparam logic [31:0] DSISR_STORE  = 32'h0A00_0000;
  localparam logic [31:0] DSISR_LOAD   = 32'h0800_0000;
  localparam int ERR_IMISS_BIT = 18;
  localparam int ERR_SMISS_BIT = 16;
  localparam int ERR_KEY_BIT   = 19;
endpackage

// File: rtl/sxm_seg_decode.sv
module sxm_seg_decode import sxm_pkg::*; #(
  parameter int NSEG       = 16,
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int VSID_W     = 24,
  parameter int API_W      = 6
) (
  input  logic [ADDR_W-1:0]         ea,
  input  logic [NSEG*SR_W-1:0]      sr_flat,
  input  logic                      user,
  output logic                      key,
  output logic                      t_bit,
  output logic                      n_bit,
  output logic [VSID_W-1:0]         hash,
  output logic [VSID_W+API_W:0]     ptem
);
  localparam int SEL_W = $clog2(NSEG);
  localparam int PG_W  = ADDR_W - SEL_W - PAGE_SHIFT;

  logic [SR_W-1:0] sr_arr [NSEG];
  genvar g;
  generate
    for (g = 0; g < NSEG; g++) begin : g_unpack
      assign sr_arr[g] = sr_flat[g*SR_W +: SR_W];
    end
  endgenerate

  logic [SEL_W-1:0]  idx;
  logic [SR_W-1:0]   sr;
  logic [PG_W-1:0]   pg;
  logic [VSID_W-1:0] vsid;

  assign idx   = ea[ADDR_W-1 -: SEL_W];
  assign sr    = sr_arr[idx];
  assign pg    = ea[PAGE_SHIFT +: PG_W];
  assign vsid  = sr[VSID_W-1:0];
  assign t_bit = sr[SR_T_BIT];
  assign n_bit = sr[SR_N_BIT];
  assign key   = (user & sr[SR_KP_BIT]) | (~user & sr[SR_KS_BIT]);
  assign hash  = vsid ^ VSID_W'(pg);
  assign ptem  = {vsid, 1'b0, pg[PG_W-1 -: API_W]};

  logic dec_unused;
  assign dec_unused = ^{ea[PAGE_SHIFT-1:0], sr[SR_N_BIT-1:VSID_W]};
endmodule

// File: rtl/sxm_group_addr.sv
module sxm_group_addr #(
  parameter int HASH_W      = 24,
  parameter int MASK_W      = 9,
  parameter int ADDR_W      = 32,
  parameter int GROUP_SHIFT = 6
) (
  input  logic [HASH_W-1:0] hash,
  input  logic [ADDR_W-1:0] base,
  input  logic [MASK_W-1:0] mask,
  output logic [ADDR_W-1:0] grp_pri,
  output logic [ADDR_W-1:0] grp_sec
);
  localparam int LOW_W = 10;
  localparam int MT    = MASK_W + LOW_W;

  logic [ADDR_W-1:0] grp [2];
  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_grp
      logic [HASH_W-1:0] hsrc;
      logic [MT-1:0]     sel;
      assign hsrc   = (g == 0) ? hash : ~hash;
      assign sel    = hsrc[MT-1:0] & {mask, {LOW_W{1'b1}}};
      assign grp[g] = base + ({{(ADDR_W-MT){1'b0}}, sel} << GROUP_SHIFT);
    end
    if (HASH_W > MT) begin : g_spare
      logic grp_unused;
      assign grp_unused = ^hash[HASH_W-1:MT];
    end
  endgenerate

  assign grp_pri = grp[0];
  assign grp_sec = grp[1];
endmodule

// File: rtl/sxm_classify.sv
module sxm_classify import sxm_pkg::*; (
  input  logic [1:0]  kind,
  input  logic        real_mode,
  input  logic        bat_hit,
  input  logic        bat_ok,
  input  logic        t_bit,
  input  logic        n_bit,
  input  logic        key,
  input  logic        tlb_hit,
  input  logic        tlb_ok,
  output outcome_e    outcome,
  output pa_src_e     pa_src,
  output logic        lookup,
  output logic [31:0] err_val,
  output logic [31:0] dsisr_val
);
  logic fetch, store;
  assign fetch = (acc_kind_e'(kind) == ACC_FETCH);
  assign store = (acc_kind_e'(kind) == ACC_STORE);

  always_comb begin
    outcome = OUT_GRANT;
    pa_src  = PA_EA;
    lookup  = 1'b0;
    if (real_mode) begin
      pa_src = PA_EA;
    end else if (bat_hit && bat_ok) begin
      pa_src = PA_BAT;
    end else if (fetch && (t_bit || n_bit)) begin
      outcome = OUT_NOEXEC;
    end else if (t_bit) begin
      pa_src = PA_EA;
    end else begin
      lookup = 1'b1;
      if (!tlb_hit)     outcome = OUT_MISS;
      else if (!tlb_ok) outcome = OUT_PROT;
      else              pa_src  = PA_TLB;
    end
  end

  always_comb begin
    err_val = '0;
    case (outcome)
      OUT_NOEXEC: err_val = ERR_NOEXEC;
      OUT_PROT:   err_val = fetch ? ERR_PROT_I : 32'h0;
      OUT_MISS: begin
        err_val[ERR_KEY_BIT] = key;
        if (fetch)      err_val[ERR_IMISS_BIT] = 1'b1;
        else if (store) err_val[ERR_SMISS_BIT] = 1'b1;
      end
      default:    err_val = '0;
    endcase
  end

  assign dsisr_val = store ? DSISR_STORE : DSISR_LOAD;
endmodule

// File: rtl/seg_xlate_front.sv
module seg_xlate_front import sxm_pkg::*; #(
  parameter int NSEG        = 16,
  parameter int ADDR_W      = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int VSID_W      = 24,
  parameter int API_W       = 6,
  parameter int MASK_W      = 9,
  parameter int GROUP_SHIFT = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_ea,
  input  logic [1:0]                req_kind,
  input  logic                      user_mode,
  input  logic                      ir_en,
  input  logic                      dr_en,
  input  logic [NSEG*32-1:0]        seg_regs,
  input  logic [ADDR_W-1:0]         htab_base,
  input  logic [MASK_W-1:0]         htab_mask,
  input  logic                      bat_hit,
  input  logic                      bat_ok,
  input  logic [ADDR_W-1:0]         bat_pa,
  output logic                      tlb_lookup,
  output logic [ADDR_W-1:0]         tlb_ea,
  output logic [VSID_W+API_W:0]     tlb_ptem,
  input  logic                      tlb_hit,
  input  logic                      tlb_ok,
  input  logic [ADDR_W-1:0]         tlb_pa,
  output logic                      rsp_valid,
  output logic                      rsp_grant,
  output logic                      rsp_fault,
  output logic [ADDR_W-1:0]         rsp_pa,
  output logic [31:0]               err_code,
  output logic [31:0]               dsisr,
  output logic [ADDR_W-1:0]         dar,
  output logic [ADDR_W-1:0]         imiss,
  output logic [31:0]               icmp,
  output logic [ADDR_W-1:0]         dmiss,
  output logic [31:0]               dcmp,
  output logic [ADDR_W-1:0]         hash1,
  output logic [ADDR_W-1:0]         hash2
);
  localparam int PTEM_W = VSID_W + API_W + 1;

  logic fetch, real_mode, key, t_bit, n_bit, lookup;
  logic [VSID_W-1:0] hash;
  logic [PTEM_W-1:0] ptem;
  logic [ADDR_W-1:0] grp_pri, grp_sec, pa_val;
  logic [31:0] err_val, dsisr_val, cmp_val;
  outcome_e outcome;
  pa_src_e  pa_src;

  assign fetch     = (acc_kind_e'(req_kind) == ACC_FETCH);
  assign real_mode = fetch ? ~ir_en : ~dr_en;
  assign cmp_val   = 32'h8000_0000 | 32'(ptem);

  sxm_seg_decode #(.NSEG(NSEG), .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
                   .VSID_W(VSID_W), .API_W(API_W)) u_dec (
    .ea(req_ea), .sr_flat(seg_regs), .user(user_mode), .key(key),
    .t_bit(t_bit), .n_bit(n_bit), .hash(hash), .ptem(ptem));

  sxm_group_addr #(.HASH_W(VSID_W), .MASK_W(MASK_W), .ADDR_W(ADDR_W),
                   .GROUP_SHIFT(GROUP_SHIFT)) u_grp (
    .hash(hash), .base(htab_base), .mask(htab_mask),
    .grp_pri(grp_pri), .grp_sec(grp_sec));

  sxm_classify u_cls (
    .kind(req_kind), .real_mode(real_mode), .bat_hit(bat_hit), .bat_ok(bat_ok),
    .t_bit(t_bit), .n_bit(n_bit), .key(key), .tlb_hit(tlb_hit), .tlb_ok(tlb_ok),
    .outcome(outcome), .pa_src(pa_src), .lookup(lookup),
    .err_val(err_val), .dsisr_val(dsisr_val));

  assign tlb_lookup = req_valid & lookup;
  assign tlb_ea     = req_ea;
  assign tlb_ptem   = ptem;

  always_comb begin
    case (pa_src)
      PA_BAT:  pa_val = bat_pa;
      PA_TLB:  pa_val = tlb_pa;
      default: pa_val = req_ea;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0; rsp_grant <= 1'b0; rsp_fault <= 1'b0;
      rsp_pa <= '0; err_code <= '0; dsisr <= '0; dar <= '0;
      imiss <= '0; icmp <= '0; dmiss <= '0; dcmp <= '0;
      hash1 <= '0; hash2 <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_grant <= req_valid && (outcome == OUT_GRANT);
      rsp_fault <= req_valid && (outcome != OUT_GRANT);
      if (req_valid && outcome == OUT_GRANT) rsp_pa <= pa_val;
      if (req_valid && outcome != OUT_GRANT) begin
        err_code <= err_val;
        if (outcome == OUT_MISS) begin
          hash1 <= grp_pri;
          hash2 <= grp_sec;
          if (fetch) begin imiss <= req_ea; icmp <= cmp_val; end
          else       begin dmiss <= req_ea; dcmp <= cmp_val; end
        end
        if (outcome == OUT_PROT && !fetch) begin
          dar   <= req_ea;
          dsisr <= dsisr_val;
        end
      end
    end
  end

  p_resp_lat_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_one_outcome_r1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_grant ^ rsp_fault));
  p_real_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && fetch && !ir_en) |=> (rsp_grant && rsp_pa == $past(req_ea)));
  p_no_lookup_real_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && real_mode) |-> !tlb_lookup);
  p_cmp_marker_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(icmp) |-> icmp[31]);
  p_dar_on_fault_r13: assert property (@(posedge clk) disable iff (rst)
    !$stable(dar) |-> rsp_fault);
  p_imiss_on_fault_r13: assert property (@(posedge clk) disable iff (rst)
    !$stable(imiss) |-> rsp_fault);
endmodule

// File: tb/sim_seg_xlate_front.sv
module sim_seg_xlate_front;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] req_ea = '0;
  logic [1:0] req_kind = '0;
  logic user_mode = 1'b0, ir_en = 1'b1, dr_en = 1'b1;
  logic [511:0] seg_regs = '0;
  logic [31:0] htab_base = 32'h0F00_0000;
  logic [8:0] htab_mask = 9'h1F3;
  logic bat_hit = 1'b0, bat_ok = 1'b0;
  logic [31:0] bat_pa = '0;
  logic tlb_lookup;
  logic [31:0] tlb_ea;
  logic [30:0] tlb_ptem;
  logic tlb_hit = 1'b0, tlb_ok = 1'b0;
  logic [31:0] tlb_pa = '0;
  logic rsp_valid, rsp_grant, rsp_fault;
  logic [31:0] rsp_pa, err_code, dsisr, dar, imiss, icmp, dmiss, dcmp, hash1, hash2;

  always #(PERIOD/2) clk = ~clk;

  seg_xlate_front u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ea(req_ea), .req_kind(req_kind),
    .user_mode(user_mode), .ir_en(ir_en), .dr_en(dr_en), .seg_regs(seg_regs),
    .htab_base(htab_base), .htab_mask(htab_mask), .bat_hit(bat_hit), .bat_ok(bat_ok),
    .bat_pa(bat_pa), .tlb_lookup(tlb_lookup), .tlb_ea(tlb_ea), .tlb_ptem(tlb_ptem),
    .tlb_hit(tlb_hit), .tlb_ok(tlb_ok), .tlb_pa(tlb_pa), .rsp_valid(rsp_valid),
    .rsp_grant(rsp_grant), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa), .err_code(err_code),
    .dsisr(dsisr), .dar(dar), .imiss(imiss), .icmp(icmp), .dmiss(dmiss), .dcmp(dcmp),
    .hash1(hash1), .hash2(hash2));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] e_err = 0, e_dsisr = 0, e_dar = 0, e_imiss = 0, e_icmp = 0;
  logic [31:0] e_dmiss = 0, e_dcmp = 0, e_h1 = 0, e_h2 = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sr_of(int i);
    logic [31:0] s;
    s[31]    = (i == 13);
    s[30]    = i[0];
    s[29]    = i[1];
    s[28]    = (i == 5) || (i == 9);
    s[27:24] = 4'h0;
    s[23:0]  = 24'h0A5000 ^ (24'(i) * 24'h01F3B7);
    return s;
  endfunction

  function automatic logic [31:0] grp_of(logic [23:0] h);
    logic [18:0] sel;
    sel = h[18:0] & {9'h1F3, 10'h3FF};
    return 32'h0F00_0000 + ({13'b0, sel} << 6);
  endfunction

  task automatic side_checks(string tag);
    chk({tag, " R13 err_code"}, err_code, e_err);
    chk({tag, " R12 dsisr"}, dsisr, e_dsisr);
    chk({tag, " R12 dar"}, dar, e_dar);
    chk({tag, " R9 imiss"}, imiss, e_imiss);
    chk({tag, " R9 icmp"}, icmp, e_icmp);
    chk({tag, " R9 dmiss"}, dmiss, e_dmiss);
    chk({tag, " R9 dcmp"}, dcmp, e_dcmp);
    chk({tag, " R10 hash1"}, hash1, e_h1);
    chk({tag, " R10 hash2"}, hash2, e_h2);
  endtask

  // sc: 0 real mode, 1 bat ok, 2 bat denied+hit ok, 3 hit denied, 4 miss, 5 hit ok, 6 other-kind enable off + miss
  task automatic do_one(int seg, int kind, bit usr, int sc, int cnt);
    logic [31:0] ea, sr, e_pa;
    logic [23:0] vsid, h;
    logic [15:0] pg;
    logic [30:0] ptem;
    bit fetch, store, key, e_grant, e_lookup;
    fetch = (kind == 2); store = (kind == 1);
    ea = {4'(seg), 28'((cnt + 3) * 32'h0123_4577 ^ 32'h09AB_CDEF)};
    req_valid = 1'b1; req_ea = ea; req_kind = 2'(kind); user_mode = usr;
    ir_en = 1'b1; dr_en = 1'b1;
    if (sc == 0) begin ir_en = !fetch; dr_en = fetch; end
    if (sc == 6) begin ir_en = fetch; dr_en = !fetch; end
    bat_hit = (sc == 1) || (sc == 2) || (sc == 0 && cnt[0]);
    bat_ok  = (sc == 1) || (sc == 0);
    bat_pa  = 32'hB000_0000 | {15'b0, ea[16:0]};
    tlb_hit = (sc == 2) || (sc == 3) || (sc == 5);
    tlb_ok  = (sc != 3);
    tlb_pa  = ea ^ 32'h5A00_0000;

    sr = sr_of(seg); vsid = sr[23:0]; pg = ea[27:12];
    h = vsid ^ {8'h0, pg};
    ptem = {vsid, 1'b0, pg[15:10]};
    key = (usr & sr[29]) | (!usr & sr[30]);
    e_grant = 1'b1; e_lookup = 1'b0; e_pa = ea;
    if (sc == 0) e_pa = ea;
    else if (sc == 1) e_pa = bat_pa;
    else if (fetch && (sr[31] || sr[28])) begin e_grant = 0; e_err = 32'h1000_0000; end
    else if (sr[31]) e_pa = ea;
    else begin
      e_lookup = 1'b1;
      if (tlb_hit && tlb_ok) e_pa = tlb_pa;
      else if (tlb_hit) begin
        e_grant = 0;
        if (fetch) e_err = 32'h0800_0000;
        else begin e_err = 0; e_dar = ea; e_dsisr = store ? 32'h0A00_0000 : 32'h0800_0000; end
      end else begin
        e_grant = 0;
        e_err = (32'(key) << 19) | (fetch ? 32'h0004_0000 : store ? 32'h0001_0000 : 32'h0);
        if (fetch) begin e_imiss = ea; e_icmp = {1'b1, ptem}; end
        else begin e_dmiss = ea; e_dcmp = {1'b1, ptem}; end
        e_h1 = grp_of(h); e_h2 = grp_of(~h);
      end
    end
    #1;
    chk("R2/R5 tlb_lookup", 32'(tlb_lookup), 32'(e_lookup));
    chk("R5 tlb_ea", tlb_ea, ea);
    if (e_lookup) chk("R5 tlb_ptem", 32'(tlb_ptem), 32'(ptem));
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R1 rsp_grant", 32'(rsp_grant), 32'(e_grant));
    chk("R1 rsp_fault", 32'(rsp_fault), 32'(!e_grant));
    if (e_grant) chk("R2/R3/R7/R8 rsp_pa", rsp_pa, e_pa);
    side_checks("R4/R6/R11");
    if (cnt % 8 == 0) begin
      @(negedge clk);
      chk("R1 pulse ends", 32'(rsp_valid), 32'd0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cnt;
    for (int i = 0; i < 16; i++) seg_regs[i*32 +: 32] = sr_of(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    side_checks("reset");
    cnt = 0;
    for (int seg = 0; seg < 16; seg++)
      for (int kind = 0; kind < 3; kind++)
        for (int usr = 0; usr < 2; usr++)
          for (int sc = 0; sc < 7; sc++) begin
            do_one(seg, kind, usr[0], sc, cnt);
            cnt++;
          end
    finish_run();
  end
endmodule